// File: doc/BRIEF.md
# Bus Target Address Front End with Four-State Strap Decoding

This block is the first stage of a two-wire serial bus target (I2C/SMBus style). It cleans up the clock and data lines, recognises START, repeated START and STOP conditions, and shifts in the address byte that follows each START. It never drives the clock. It only pulls the data line low, as an open-drain output, when it acknowledges its own address.

The block builds its 7-bit device address from two strap pins. Each strap can be wired to ground, to the supply, to the data line or to the clock line. It classifies each strap on every transaction by comparing the filtered strap level against the filtered bus lines from the START edge onward. On a match it acknowledges the byte, pulses a one-cycle notice and latches the direction bit for the downstream byte handler. On a mismatch it stays silent until the next START or STOP.

Top module: `i2c_strap_target`

## Requirements
- R1: A low or high pulse shorter than three system clocks on the clock or data line is suppressed. Such a pulse on the data line while the clock is high does not set `busy_o`.
- R2: `busy_o` is 0 after reset. It becomes 1 after a START (data falls while the clock is high) and returns to 0 after a STOP (data rises while the clock is high).
- R3: The device address is `{3'b100, code(a1), code(a0)}`, with a1 in bits 3:2 and a0 in bits 1:0. The strap codes are: tied low = 2'b00, tied high = 2'b01, follows the data line = 2'b10, follows the clock line = 2'b11. `dev_addr_o` shows the decoded address.
- R4: The straps are classified again after every START, so a strap rewired between transactions is decoded correctly for the next transaction.
- R5: When the first seven received bits (most significant first) equal the device address, `sda_oe_o` holds the data line low through the high phase of the ninth clock. It releases the line after that clock falls.
- R6: When the address differs, the data line is never pulled low, `addr_match_o` stays 0, and the bytes that follow are ignored until the next START or STOP.
- R7: On a match, `addr_match_o` is high for exactly one cycle, following the eighth clock rising edge. `rw_o` then holds the eighth bit (1 = read, 0 = write).
- R8: A repeated START discards a partly or fully received address byte and starts reception and strap classification again from the first bit.
- R9: `sda_oe_o` only rises while the filtered clock line is low, so the block itself never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a1_i | input | 1 | Upper address strap pin |
| strap_a0_i | input | 1 | Lower address strap pin |
| sda_oe_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| addr_match_o | output | 1 | One-cycle pulse when the address byte matches |
| rw_o | output | 1 | Direction bit of the last matched address byte |
| busy_o | output | 1 | High from START until STOP |
| dev_addr_o | output | 7 | Decoded 7-bit device address |

## Verification
On every cycle, the assertions check these properties: the filter output only moves to a level that was held for three samples; a strap code stays unchanged outside the classification window; the match pulse lasts one cycle and follows a clock rise; the pull-low only begins with the clock low and only while the bus is busy; and busy only falls after a STOP. Several behaviours can only be shown by the bench scenarios, by watching the bus line. These are the decoding of all four strap states on each pin, decoding again after the straps are rewired, the acknowledge window, silence on a mismatched address, and recovery through a repeated START.

// File: rtl/i2cst_pkg.sv
// Shared types and constants for the strap-addressed bus target.
package i2cst_pkg;

    localparam int ADDR_W = 7;
    localparam logic [2:0] ADDR_PREFIX = 3'b100;

    // Two-bit code per strap; it goes straight into the address field.
    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_HIGH = 2'b01,
        STRAP_SDA  = 2'b10,
        STRAP_SCL  = 2'b11
    } strap_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_HANDOFF,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2cst_glitch_filter.sv
// Input conditioner for one bus or strap pin.
// The pin first passes through a SYNC_STAGES-deep synchronizer. The output
// moves only after STABLE_LEN consecutive synchronized samples agree.
// Assumes: the system clock samples each bus phase several times.
module i2cst_glitch_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   STABLE_LEN  = 3,
    parameter logic RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [STABLE_LEN-1:0]  hist_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RESET_VAL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Keep the most recent synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= {STABLE_LEN{RESET_VAL}};
        else        hist_q <= {hist_q[STABLE_LEN-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Move the output only on a unanimous history.
    always_ff @(posedge clk) begin
        if (!rst_n)           filt_o <= RESET_VAL;
        else if (&hist_q)     filt_o <= 1'b1;
        else if (~|hist_q)    filt_o <= 1'b0;
    end

    // R1: a change of output must be backed by a full agreeing history
    assert_filter_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(hist_q) == {STABLE_LEN{filt_o}}));

endmodule

// File: rtl/i2cst_strap_class.sv
// Classifier for one four-state address strap.
// It tracks four candidate explanations of the strap: constant low, constant
// high, follows data, follows clock. A START reloads the candidates with the
// current sample. Each enabled sample removes every candidate it contradicts.
// The code is the survivor with the highest priority (low, high, data, clock),
// and low when none survive.
// Assumes: all inputs come from identically delayed filters.
module i2cst_strap_class
    import i2cst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart_i,
    input  logic        sample_en_i,
    input  logic        strap_i,
    input  logic        sda_i,
    input  logic        scl_i,
    output strap_code_e code_o
);

    logic [3:0] cand_q;
    logic [3:0] agree;

    // Which explanations are consistent with this sample.
    always_comb begin
        agree[STRAP_LOW]  = ~strap_i;
        agree[STRAP_HIGH] = strap_i;
        agree[STRAP_SDA]  = ~(strap_i ^ sda_i);
        agree[STRAP_SCL]  = ~(strap_i ^ scl_i);
    end

    // Reload on START, narrow while the window is open, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cand_q <= 4'b0001;
        else if (restart_i)   cand_q <= agree;
        else if (sample_en_i) cand_q <= cand_q & agree;
    end

    // Priority pick of the surviving explanation.
    always_comb begin
        if (cand_q[STRAP_LOW])       code_o = STRAP_LOW;
        else if (cand_q[STRAP_HIGH]) code_o = STRAP_HIGH;
        else if (cand_q[STRAP_SDA])  code_o = STRAP_SDA;
        else if (cand_q[STRAP_SCL])  code_o = STRAP_SCL;
        else                         code_o = STRAP_LOW;
    end

    // R3: the code is frozen while the classification window is closed
    assert_code_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !sample_en_i) |=> $stable(code_o));

endmodule

// File: rtl/i2c_strap_target.sv
// Bus target front end: filters the pins, finds START/STOP, receives the
// address byte, decodes the own address from two four-state straps,
// acknowledges a match with an open-drain pull-low, and reports the match
// and the direction bit.
// Assumes: clk runs at least 8x the bus clock, and sda_oe_o drives an
// open-drain pad whose level comes back on sda_i.
module i2c_strap_target
    import i2cst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_LEN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_a1_i,
    input  logic              strap_a0_i,
    output logic              sda_oe_o,
    output logic              addr_match_o,
    output logic              rw_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] dev_addr_o
);

    localparam int NLINES = 4;
    localparam int NSTRAP = 2;
    localparam int CNT_W  = $clog2(ADDR_W + 1);
    localparam int L_SCL  = 0;
    localparam int L_SDA  = 1;

    logic [NLINES-1:0] raw_vec;
    logic [NLINES-1:0] filt_vec;
    logic              scl_f, sda_f, scl_q, sda_q;
    logic              start_det, stop_det, scl_rise, scl_fall;
    logic              class_en;
    strap_code_e       strap_code [NSTRAP];

    tgt_state_e        state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [ADDR_W-1:0] shift_q;
    logic              rw_q, pulse_q, oe_q, busy_q;

    // Pin order: clock, data, then the a1 and a0 straps.
    assign raw_vec = {strap_a0_i, strap_a1_i, sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2cst_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .STABLE_LEN (STABLE_LEN),
            .RESET_VAL  (1'b1)
        ) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_vec[g]),
            .filt_o(filt_vec[g])
        );
    end

    assign scl_f = filt_vec[L_SCL];
    assign sda_f = filt_vec[L_SDA];

    // Hold the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;

    // Classification runs from the START up to the seventh rising edge.
    assign class_en = (state_q == ST_ADDR) && (bit_cnt_q < CNT_W'(ADDR_W));

    for (genvar s = 0; s < NSTRAP; s++) begin : g_strap
        i2cst_strap_class i_class (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart_i  (start_det),
            .sample_en_i(class_en),
            .strap_i    (filt_vec[2 + s]),
            .sda_i      (sda_f),
            .scl_i      (scl_f),
            .code_o     (strap_code[s])
        );
    end

    assign dev_addr_o = {ADDR_PREFIX, strap_code[0], strap_code[1]};

    // Main sequencer: address reception, acknowledge, handoff or ignore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shift_q   <= '0;
            rw_q      <= 1'b0;
            pulse_q   <= 1'b0;
            oe_q      <= 1'b0;
            busy_q    <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (start_det) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
                busy_q    <= 1'b1;
            end else if (stop_det) begin
                state_q   <= ST_IDLE;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
                busy_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            if (bit_cnt_q == CNT_W'(ADDR_W)) begin
                                rw_q <= sda_f;
                                if (shift_q == dev_addr_o) begin
                                    pulse_q <= 1'b1;
                                    state_q <= ST_ACK_WAIT;
                                end else begin
                                    state_q <= ST_IGNORE;
                                end
                            end else begin
                                shift_q   <= {shift_q[ADDR_W-2:0], sda_f};
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b1;
                            state_q <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_HANDOFF;
                        end
                    end
                    ST_IDLE, ST_HANDOFF, ST_IGNORE: begin
                        state_q <= state_q;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe_o     = oe_q;
    assign addr_match_o = pulse_q;
    assign rw_o         = rw_q;
    assign busy_o       = busy_q;

    // R7: the match notice lasts exactly one cycle
    assert_match_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match_o |=> !addr_match_o);

    // R7: the match notice follows a clock rise
    assert_match_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match_o |-> $past(scl_rise));

    // R9: pull-low only starts with the clock low
    assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_f);

    // R5: acknowledge drive only inside a busy transaction
    assert_oe_within_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> busy_o);

    // R2: busy only drops after a STOP
    assert_busy_fall_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(stop_det));

endmodule

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;

    localparam int HALF = 12;

    typedef struct packed {
        logic       rw;
        logic [6:0] addr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    int   mode_a1 = 0;
    int   mode_a0 = 0;
    logic strap_a1, strap_a0;
    logic sda_oe, addr_match, rw, busy;
    logic [6:0] dev_addr;
    wire  sda_line = host_sda & ~sda_oe;
    wire  scl_line = host_scl;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    function automatic logic strap_level(int m, logic d, logic c);
        case (m)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return d;
            default: return c;
        endcase
    endfunction

    always_comb strap_a1 = strap_level(mode_a1, sda_line, scl_line);
    always_comb strap_a0 = strap_level(mode_a0, sda_line, scl_line);

    i2c_strap_target i_i2c_strap_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .strap_a1_i  (strap_a1),
        .strap_a0_i  (strap_a0),
        .sda_oe_o    (sda_oe),
        .addr_match_o(addr_match),
        .rw_o        (rw),
        .busy_o      (busy),
        .dev_addr_o  (dev_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; host_scl = 1'b1; wclk(HALF);
        host_sda = 1'b0; wclk(HALF);
        host_scl = 1'b0; wclk(HALF);
    endtask

    task automatic bus_rstart();
        host_sda = 1'b1; wclk(HALF);
        host_scl = 1'b1; wclk(HALF);
        host_sda = 1'b0; wclk(HALF);
        host_scl = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wclk(HALF);
        host_scl = 1'b1; wclk(HALF);
        host_sda = 1'b1; wclk(HALF);
    endtask

    task automatic bus_bit(input logic b);
        host_sda = b;    wclk(HALF);
        host_scl = 1'b1; wclk(HALF);
        host_scl = 1'b0;
    endtask

    // Driver: sends an address byte, queues the expected notice, checks the ninth clock.
    task automatic send_addr(input logic [6:0] a, input logic dir,
                             input bit want_ack, input string req);
        exp_t e;
        e.rw = dir; e.addr = a;
        if (want_ack) sb_q.push_back(e);
        for (int i = 6; i >= 0; i--) bus_bit(a[i]);
        bus_bit(dir);
        host_sda = 1'b1; wclk(HALF);
        host_scl = 1'b1; wclk(HALF / 2);
        chk(sda_line == !want_ack, req, "data level in ninth clock high",
            int'(sda_line), int'(!want_ack));
        wclk(HALF - HALF / 2);
        host_scl = 1'b0; wclk(HALF - 1);
        chk(sda_line == 1'b1, req, "data released after ninth clock",
            int'(sda_line), 1);
        wclk(1);
    endtask

    // Monitor: pops the scoreboard on every match notice.
    always @(negedge clk) begin
        if (rst_n && addr_match) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected match notice", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rw == e.rw, "R7", "direction bit", int'(rw), int'(e.rw));
                chk(dev_addr == e.addr, "R3", "decoded address",
                    int'(dev_addr), int'(e.addr));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int combos[8][2] = '{'{0,0}, '{1,1}, '{2,3}, '{3,2}, '{0,2}, '{3,1}, '{2,2}, '{3,3}};
        wclk(4);
        rst_n = 1'b1;
        wclk(10);
        // R2: reset state
        chk(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
        chk(sda_oe == 1'b0, "R9", "pull-low after reset", int'(sda_oe), 0);
        chk(addr_match == 1'b0, "R7", "match after reset", int'(addr_match), 0);

        // R1: short data glitch with the clock high is not a START
        host_sda = 1'b0; wclk(2); host_sda = 1'b1; wclk(12);
        chk(busy == 1'b0, "R1", "busy after data glitch", int'(busy), 0);
        host_scl = 1'b0; wclk(2); host_scl = 1'b1;
        host_sda = 1'b0; wclk(1); host_sda = 1'b1; wclk(12);
        chk(busy == 1'b0, "R1", "busy after clock and data glitches", int'(busy), 0);

        // R3, R4: every strap state on both pins, rewired between transactions
        for (int k = 0; k < 8; k++) begin
            logic [6:0] a;
            mode_a1 = combos[k][0];
            mode_a0 = combos[k][1];
            wclk(HALF);
            a = {3'b100, 2'(mode_a1), 2'(mode_a0)};
            bus_start();
            chk(busy == 1'b1, "R2", "busy after START", int'(busy), 1);
            send_addr(a, 1'(k % 2), 1'b1, "R5");
            bus_stop();
            chk(busy == 1'b0, "R2", "busy after STOP", int'(busy), 0);
            chk(dev_addr == a, "R4", "address after rewired straps",
                int'(dev_addr), int'(a));
        end

        // R6: wrong address is silent, following byte ignored
        mode_a1 = 1; mode_a0 = 0; wclk(HALF);
        bus_start();
        send_addr(7'b1000101, 1'b0, 1'b0, "R6");
        send_addr(7'b1000100, 1'b0, 1'b0, "R6");
        bus_stop();

        // R8: repeated START after a refused address
        bus_start();
        send_addr(7'b1001111, 1'b1, 1'b0, "R6");
        bus_rstart();
        send_addr(7'b1000100, 1'b1, 1'b1, "R8");
        bus_stop();

        // R8: repeated START in the middle of an address byte
        mode_a1 = 3; mode_a0 = 2; wclk(HALF);
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b0); bus_bit(1'b1);
        bus_rstart();
        send_addr(7'b1001110, 1'b0, 1'b1, "R8");
        bus_stop();

        wclk(20);
        chk(sb_q.size() == 0, "R7", "match notices still pending", sb_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule